// File: doc/BRIEF.md
# Interval Down-Counter with Auto-Reload

This block is a down-counting interval timer that steps only on cycles where a time-base tick enable is high, not on every clock. Software starts it by writing a start value through a narrow register-write port. The same value goes into the live counter and into a reload latch. When the counter holds 1 and a tick arrives, the timer produces an event. It then either refills from the reload latch or drops to zero and stops, as a control bit selects.

Each event sets a sticky status flag, which software clears by writing a 1 to it. An interrupt request is raised while that flag and an interrupt-enable control bit are both set. The counter is driven by a two-state machine. In STOPPED the count is zero and ticks are ignored. In RUNNING the count is non-zero and each tick decrements it. The machine has four named transitions. ARM (STOPPED to RUNNING) happens on a write of a non-zero value. DISARM (RUNNING to STOPPED) happens on a write of zero. EXPIRE (RUNNING to STOPPED) happens on an event with reload off. REARM (RUNNING to RUNNING) happens on an event with reload on. A write of a non-zero value while RUNNING restarts the count and stays in RUNNING.

Register selector codes on `wr_sel_i` are as follows. 0 selects the counter. 1 selects the control register, where bit 0 is reload enable and bit 1 is interrupt enable. 2 selects status, where bit 0 is write-1-to-clear. Code 3 is unused.

Top module: `interval_timer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the count, the reload latch, both control bits and the status flag, and holds `event_o` and `irq_o` low.
- R2: A write with selector 0 loads `wr_data_i` into the counter and the reload latch at that edge, so `count_o` shows the value in the next cycle.
- R3: In RUNNING, the count decreases by exactly 1 at each edge where `tick_i` is high, and holds at edges where `tick_i` is low.
- R4: An edge with `tick_i` high while the count is 1 (and no counter write) makes `event_o` high for exactly the following cycle. `event_o` is high at no other time.
- R5: With control bit 0 set at the event edge, the count becomes the value of the last counter write rather than 0. In this mode the count never shows 0 while running; a reload value of 1 gives an event on every tick.
- R6: With control bit 0 clear at the event edge, the count goes from 1 to 0 and then stays at 0 with no further events until the next counter write.
- R7: A counter write in the same cycle as a tick takes priority. The written value appears unchanged, with no decrement and no event.
- R8: Writing 0 to the counter stops the timer. No event follows, whether or not reload is enabled.
- R9: Each event sets the status flag, which stays set until a status write with data bit 0 equal to 1. A status write with bit 0 equal to 0 has no effect, and an event in the same cycle as a clear leaves the flag set.
- R10: `irq_o` is high exactly while the status flag and control bit 1 are both set.
- R11: A control write updates `reload_en_o` (data bit 0) and `irq_en_o` (data bit 1) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selector: 0 counter, 1 control, 2 status |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| reload_en_o | output | 1 | Control bit 0: reload enable |
| irq_en_o | output | 1 | Control bit 1: interrupt enable |
| status_o | output | 1 | Sticky event flag |
| event_o | output | 1 | One-cycle event pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong state or wrong count shows on `count_o` at the first tick after the fault: a count that skips a value, reaches 0 in reload mode, or moves while STOPPED. A wrong reload latch stays hidden until the next event. It then shows as a wrong refill value in the cycle after that event, so reload runs cover several periods, including a reload value of 1. Priority faults between a write and a tick, or between an event and a clear, show up only in a cycle where both occur, so both collisions are driven on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_e;

    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_COUNT  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STATUS = 2'd2;

    localparam int CTRL_RELOAD_BIT = 0;
    localparam int CTRL_IRQEN_BIT  = 1;
    localparam int STAT_CLR_BIT    = 0;

endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode
    import tmr_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic             wr_count,
    output logic             wr_ctrl,
    output logic             wr_status
);

    always_comb begin
        wr_count  = 1'b0;
        wr_ctrl   = 1'b0;
        wr_status = 1'b0;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_COUNT:  wr_count  = 1'b1;
                SEL_CTRL:   wr_ctrl   = 1'b1;
                SEL_STATUS: wr_status = 1'b1;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_en,
    output logic [CNT_W-1:0] count,
    output logic             fire,
    output logic             event_q
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q, reload_d;

    // State and datapath register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_STOPPED;
            count_q  <= ZERO;
            reload_q <= ZERO;
            event_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            count_q  <= count_d;
            reload_q <= reload_d;
            event_q  <= fire;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        reload_d = reload_q;
        fire     = 1'b0;
        if (load_req) begin
            // ARM / DISARM / restart: a write beats any tick
            count_d  = load_val;
            reload_d = load_val;
            state_d  = (load_val == ZERO) ? ST_STOPPED : ST_RUNNING;
        end else begin
            unique case (state_q)
                ST_STOPPED: begin
                    state_d = ST_STOPPED;
                end
                ST_RUNNING: begin
                    if (tick) begin
                        if (count_q == ONE) begin
                            fire = 1'b1;
                            if (reload_en) begin
                                count_d = reload_q;          // REARM
                            end else begin
                                count_d = ZERO;              // EXPIRE
                                state_d = ST_STOPPED;
                            end
                        end else begin
                            count_d = count_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_STOPPED;
                    count_d = ZERO;
                end
            endcase
        end
    end

    assign count = count_q;

endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctrl,
    input  logic wr_status,
    input  logic data_reload,
    input  logic data_irqen,
    input  logic data_clr,
    input  logic fire,
    output logic reload_en,
    output logic irq_en,
    output logic status,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_en <= 1'b0;
            irq_en    <= 1'b0;
        end else if (wr_ctrl) begin
            reload_en <= data_reload;
            irq_en    <= data_irqen;
        end
    end

    // Event set wins over a coincident clear
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (fire) begin
            status <= 1'b1;
        end else if (wr_status && data_clr) begin
            status <= 1'b0;
        end
    end

    assign irq = status & irq_en;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             reload_en_o,
    output logic             irq_en_o,
    output logic             status_o,
    output logic             event_o,
    output logic             irq_o
);

    logic wr_count, wr_ctrl, wr_status;
    logic fire;

    tmr_wr_decode u_dec (
        .wr_en    (wr_en_i),
        .wr_sel   (wr_sel_i),
        .wr_count (wr_count),
        .wr_ctrl  (wr_ctrl),
        .wr_status(wr_status)
    );

    tmr_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_i),
        .load_req (wr_count),
        .load_val (wr_data_i),
        .reload_en(reload_en_o),
        .count    (count_o),
        .fire     (fire),
        .event_q  (event_o)
    );

    tmr_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_status  (wr_status),
        .data_reload(wr_data_i[CTRL_RELOAD_BIT]),
        .data_irqen (wr_data_i[CTRL_IRQEN_BIT]),
        .data_clr   (wr_data_i[STAT_CLR_BIT]),
        .fire       (fire),
        .reload_en  (reload_en_o),
        .irq_en     (irq_en_o),
        .status     (status_o),
        .irq        (irq_o)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             reload_en_o,
    input logic             irq_en_o,
    input logic             status_o,
    input logic             event_o,
    input logic             irq_o
);

    logic wcnt, wclr;
    assign wcnt = wr_en_i && (wr_sel_i == 2'd0);
    assign wclr = wr_en_i && (wr_sel_i == 2'd2) && wr_data_i[0];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !status_o && !event_o && !irq_o && !reload_en_o && !irq_en_o)); // R1

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        wcnt |=> (count_o == $past(wr_data_i) && !event_o)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wcnt) |=> $stable(count_o)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wcnt && count_o > CNT_W'(1)) |=> (count_o == $past(count_o) - CNT_W'(1))); // R3

    AST_EVENT_FIRES: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wcnt && count_o == CNT_W'(1)) |=> event_o); // R4

    AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        event_o |-> ($past(tick_i) && !$past(wcnt) && $past(count_o) == CNT_W'(1))); // R4

    AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (event_o && $past(reload_en_o)) |-> (count_o != '0)); // R5

    AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (event_o && !$past(reload_en_o)) |-> (count_o == '0)); // R6

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0 && !wcnt) |=> (count_o == '0 && !event_o)); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_o && !wclr) |=> status_o); // R9

    AST_STATUS_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        event_o |-> status_o); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_o && irq_en_o)); // R10

endmodule

bind interval_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .count_o    (count_o),
    .reload_en_o(reload_en_o),
    .irq_en_o   (irq_en_o),
    .status_o   (status_o),
    .event_o    (event_o),
    .irq_o      (irq_o)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/100ps
module interval_timer_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [1:0]   wr_sel_i = 2'd0;
    logic [W-1:0] wr_data_i = '0;
    logic [W-1:0] count_o;
    logic         reload_en_o, irq_en_o, status_o, event_o, irq_o;

    always #2.5 clk = ~clk;

    interval_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .count_o(count_o),
        .reload_en_o(reload_en_o), .irq_en_o(irq_en_o), .status_o(status_o),
        .event_o(event_o), .irq_o(irq_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    ev_seen = 0;
    bit    zero_seen = 0;
    bit    armed = 0;
    bit    done = 0;
    string req = "R1";

    // behavioural reference state
    longint unsigned m_cnt = 0, m_rel = 0;
    bit m_ren = 0, m_ien = 0, m_st = 0, m_ev = 0;

    task automatic chk(string tag, string what, longint unsigned got, longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        if (!armed) return;
        chk(req, "count", count_o, m_cnt);
        chk(req, "event", event_o, m_ev);
        chk(req, "status", status_o, m_st);
        chk(req, "irq", irq_o, m_st & m_ien);
        chk(req, "reload_en", reload_en_o, m_ren);
        chk(req, "irq_en", irq_en_o, m_ien);
        if (event_o === 1'b1) ev_seen++;
        if (count_o == 0) zero_seen = 1;
    endtask

    task automatic model_step();
        bit fired;
        if (rst) begin
            m_cnt = 0; m_rel = 0; m_ren = 0; m_ien = 0; m_st = 0; m_ev = 0;
            armed = 1;
            return;
        end
        fired = 0;
        if (wr_en_i && wr_sel_i == 2'd0) begin
            m_cnt = wr_data_i;
            m_rel = wr_data_i;
        end else if (tick_i && m_cnt != 0) begin
            if (m_cnt == 1) begin
                fired = 1;
                m_cnt = m_ren ? m_rel : 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (wr_en_i && wr_sel_i == 2'd1) begin
            m_ren = wr_data_i[0];
            m_ien = wr_data_i[1];
        end
        if (fired) m_st = 1;
        else if (wr_en_i && wr_sel_i == 2'd2 && wr_data_i[0]) m_st = 0;
        m_ev = fired;
    endtask

    task automatic cyc(bit r, bit t, bit we, logic [1:0] sel, logic [W-1:0] d);
        @(negedge clk);
        compare_all();
        rst = r; tick_i = t; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        model_step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, '0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 2'd0, '0);
    endtask

    task automatic wr(logic [1:0] sel, logic [W-1:0] d);
        cyc(0, 0, 1, sel, d);
    endtask

    initial begin
        // R1: reset
        req = "R1";
        cyc(1, 1, 1, 2'd0, 32'd9);
        cyc(1, 0, 0, 2'd0, '0);
        idle(1);
        chk("R1", "count after reset", count_o, 0);
        chk("R1", "status after reset", status_o, 0);

        // R2: load
        req = "R2";
        wr(2'd0, 32'd5);
        idle(1);
        chk("R2", "loaded count", count_o, 5);

        // R3: hold without tick, step on tick
        req = "R3";
        idle(3);
        ticks(2);
        idle(1);
        chk("R3", "count after two ticks", count_o, 3);

        // R4: count down to the event
        req = "R4";
        ev_seen = 0;
        ticks(3);
        idle(2);
        chk("R4", "events from 3 ticks", ev_seen, 1);

        // R9: sticky status, write 0 ignored, write 1 clears
        req = "R9";
        idle(3);
        wr(2'd2, 32'd0);
        idle(1);
        chk("R9", "status after write of 0", status_o, 1);
        wr(2'd2, 32'd1);
        idle(1);
        chk("R9", "status after clear", status_o, 0);

        // R11 / R10: enable irq, trigger event
        req = "R11";
        wr(2'd1, 32'd2);
        idle(1);
        chk("R11", "irq_en after control write", irq_en_o, 1);
        req = "R10";
        wr(2'd0, 32'd1);
        ticks(1);
        idle(1);
        chk("R10", "irq with status and enable", irq_o, 1);
        wr(2'd2, 32'd1);
        idle(1);
        chk("R10", "irq after clear", irq_o, 0);

        // R5: auto-reload
        req = "R5";
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd3);
        idle(1);
        ev_seen = 0; zero_seen = 0;
        ticks(9);
        idle(2);
        chk("R5", "events over 9 ticks of period 3", ev_seen, 3);
        chk("R5", "zero observed in reload mode", zero_seen, 0);
        chk("R5", "count refilled", count_o, 3);
        wr(2'd0, 32'd1);
        idle(1);
        ev_seen = 0;
        ticks(4);
        idle(2);
        chk("R5", "reload of 1 fires every tick", ev_seen, 4);
        chk("R5", "count stays at 1", count_o, 1);

        // R6: one-shot
        req = "R6";
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd0);
        idle(1);
        ev_seen = 0;
        ticks(6);
        idle(2);
        chk("R6", "one-shot event count", ev_seen, 1);
        chk("R6", "count held at 0", count_o, 0);

        // R7: write beats tick
        req = "R7";
        cyc(0, 1, 1, 2'd0, 32'd7);
        idle(1);
        chk("R7", "written value not decremented", count_o, 7);
        wr(2'd0, 32'd1);
        ev_seen = 0;
        cyc(0, 1, 1, 2'd0, 32'd4);
        idle(2);
        chk("R7", "no event on write-vs-tick at 1", ev_seen, 0);
        chk("R7", "count after collision", count_o, 4);

        // R8: write 0 stops, reload on
        req = "R8";
        wr(2'd1, 32'd1);
        wr(2'd0, 32'd0);
        ev_seen = 0;
        ticks(5);
        idle(2);
        chk("R8", "no event after zero write", ev_seen, 0);
        chk("R8", "count stays 0", count_o, 0);

        // R9: event beats coincident clear
        req = "R9";
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd1);
        cyc(0, 1, 1, 2'd2, 32'd1);
        idle(1);
        chk("R9", "status set despite clear", status_o, 1);

        // R1: reset mid-run
        req = "R1";
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd20);
        cyc(1, 1, 0, 2'd0, '0);
        idle(1);
        chk("R1", "count after mid-run reset", count_o, 0);
        chk("R1", "reload_en after reset", reload_en_o, 0);
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule